// File: doc/BRIEF.md
# Suspend Write Lock and Test-Mode Control

This block sits in the control-register area of a USB device controller. Firmware writes reach it over a plain register bus made of address, data and a write strobe. While the device is suspended and the processor side has no power, floating bus lines could corrupt registers. To prevent this, the block raises a write lock when suspend is entered with the processor-power mode bit at 0. The lock stays up through resume. It drops only when firmware writes the 16-bit release code AA37h to the unlock address after resume. When the processor-power bit is 1, entering suspend does not lock anything.

The block also holds the 8-bit compliance test-mode register. Its bits force the speed mode or drive fixed line states. Bits can only be set, never cleared by firmware or by a USB bus reset. Only a power-on reset clears them. A write that would leave two bits set in one mutually exclusive group is refused and flagged. The gated strobe `wr_pass` carries the other register writes on to the rest of the chip. No data stream passes through this block, so every pin is a plain control or status signal with no handshake.

Top module: `suspend_wlock_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `locked`, `tm_err` and all six test-mode outputs are 0.
- R2: A `suspend_evt` cycle with `proc_pwr` = 0 sets `locked` to 1 in the following cycle.
- R3: A `suspend_evt` cycle with `proc_pwr` = 1 leaves `locked` unchanged.
- R4: Once `resume_evt` has been seen while locked, a write of AA37h to address UNL_ADDR (default 11h) clears `locked` in the following cycle. The same write before resume has no effect.
- R5: A write to UNL_ADDR with any other value, or AA37h written to any other address, leaves `locked` set.
- R6: While `locked` is 1, `wr_pass` is 0 and test-mode writes are dropped. While unlocked, `wr_pass` equals `wr_en` for every address other than UNL_ADDR and TM_ADDR (default 10h).
- R7: The test-mode write data bits are: bit 7 force high-speed, bit 4 force full-speed, bit 3 pseudo-random pattern, bit 2 K state, bit 1 J state, bit 0 SE0 with NAK. Bits 6 and 5 are ignored. An accepted write ORs the data into the register, which is visible on the outputs one cycle later.
- R8: The register never holds both force bits. A write that would produce both is refused.
- R9: The register never holds more than one of the four line bits. A write that would produce more is refused.
- R10: Test-mode bits are cleared only by `rst_n`. Firmware writes and `bus_rst` never clear a set bit.
- R11: `chirp_dis` is 1 exactly when either force bit is set.
- R12: A refused test-mode write leaves the register unchanged and pulses `tm_err` for exactly the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_rst | input | 1 | USB bus reset pulse (does not touch test mode) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| suspend_evt | input | 1 | One-cycle suspend-entry event |
| resume_evt | input | 1 | One-cycle resume event |
| proc_pwr | input | 1 | Processor stays powered during suspend |
| wr_pass | output | 1 | Gated write strobe for the other registers |
| locked | output | 1 | Write lock status |
| force_hs | output | 1 | Force high-speed only |
| force_fs | output | 1 | Force full-speed only |
| prbs_en | output | 1 | Drive the pseudo-random line pattern |
| k_state | output | 1 | Drive K state |
| j_state | output | 1 | Drive J state |
| se0_nak | output | 1 | Hold SE0 and NAK every valid high-speed IN token |
| chirp_dis | output | 1 | Chirp detection disabled |
| tm_err | output | 1 | One-cycle pulse on a refused test-mode write |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before use. They also assume that every input changes only between clock edges, so each event or write pulse is sampled on exactly one edge. The properties on lock transitions further assume that `suspend_evt` and an unlock write are never sampled in the same cycle, since suspend takes priority there. The bench drives every input on the falling edge and issues each event or write as a single-cycle pulse. It never overlaps a suspend event with an unlock write, so all stimulus stays inside these assumptions.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int TM_W   = 8;
  localparam int B_HS   = 7;
  localparam int B_FS   = 4;
  localparam int B_PRBS = 3;
  localparam int B_K    = 2;
  localparam int B_J    = 1;
  localparam int B_SE0  = 0;
  localparam logic [TM_W-1:0] TM_MASK = 8'b1001_1111;

  typedef enum logic [1:0] {
    LK_OPEN = 2'd0,
    LK_SUSP = 2'd1,
    LK_WAIT = 2'd2
  } lock_st_e;

  function automatic logic tm_legal(input logic [TM_W-1:0] v);
    logic [1:0] spd;
    logic [2:0] ln;
    spd = 2'(v[B_HS]) + 2'(v[B_FS]);
    ln  = 3'(v[B_PRBS]) + 3'(v[B_K]) + 3'(v[B_J]) + 3'(v[B_SE0]);
    return (spd <= 2'd1) && (ln <= 3'd1);
  endfunction
endpackage

// File: rtl/swl_lock.sv
module swl_lock
  import swl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] UNLOCK_CODE = 16'hAA37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend_evt,
  input  logic              resume_evt,
  input  logic              proc_pwr,
  input  logic              unl_wr,
  input  logic [DATA_W-1:0] unl_data,
  output logic              locked
);
  lock_st_e st_q, st_d;
  logic     code_ok;

  assign code_ok = unl_wr && (unl_data == UNLOCK_CODE);

  always_comb begin
    st_d = st_q;
    if (suspend_evt && !proc_pwr) begin
      st_d = LK_SUSP;
    end else begin
      case (st_q)
        LK_SUSP: if (resume_evt) st_d = LK_WAIT;
        LK_WAIT: if (code_ok)    st_d = LK_OPEN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_OPEN;
    else        st_q <= st_d;
  end

  assign locked = (st_q != LK_OPEN);

  a_r2_lock_on_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_evt && !proc_pwr |=> locked);

  a_r3_powered_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_evt && proc_pwr && !locked |=> !locked);

  a_r5_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !code_ok |=> locked);

  a_r4_no_unlock_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_SUSP) |=> locked);
endmodule

// File: rtl/swl_testmode.sv
module swl_testmode
  import swl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_rst,
  input  logic            tm_wr,
  input  logic [TM_W-1:0] tm_data,
  output logic [TM_W-1:0] tm_q,
  output logic            tm_err
);
  logic [TM_W-1:0] merged;
  logic            ok;

  assign merged = tm_q | (tm_data & TM_MASK);
  assign ok     = tm_legal(merged);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q   <= '0;
      tm_err <= 1'b0;
    end else begin
      tm_err <= tm_wr && !ok;
      if (tm_wr && ok) tm_q <= merged;
    end
  end

  a_r8_speed_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tm_q[B_HS], tm_q[B_FS]}));

  a_r9_line_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tm_q[B_PRBS:B_SE0]));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(tm_q) & ~tm_q) == '0));

  a_r10_busrst_keep: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst && !tm_wr |=> $stable(tm_q));

  a_r12_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    tm_err |-> $stable(tm_q));

  a_r7_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tm_q[6:5] == 2'b00);
endmodule

// File: rtl/suspend_wlock_ctrl.sv
module suspend_wlock_ctrl
  import swl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] TM_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] UNL_ADDR = 8'h11,
  parameter logic [DATA_W-1:0] UNLOCK_CODE = 16'hAA37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              suspend_evt,
  input  logic              resume_evt,
  input  logic              proc_pwr,
  output logic              wr_pass,
  output logic              locked,
  output logic              force_hs,
  output logic              force_fs,
  output logic              prbs_en,
  output logic              k_state,
  output logic              j_state,
  output logic              se0_nak,
  output logic              chirp_dis,
  output logic              tm_err
);
  logic            hit_unl, hit_tm;
  logic [TM_W-1:0] tm_q;

  assign hit_unl = wr_en && (wr_addr == UNL_ADDR);
  assign hit_tm  = wr_en && (wr_addr == TM_ADDR) && !locked;
  assign wr_pass = wr_en && !locked && (wr_addr != UNL_ADDR) && (wr_addr != TM_ADDR);

  swl_lock #(.DATA_W(DATA_W), .UNLOCK_CODE(UNLOCK_CODE)) u_lock (
    .clk(clk), .rst_n(rst_n), .suspend_evt(suspend_evt), .resume_evt(resume_evt),
    .proc_pwr(proc_pwr), .unl_wr(hit_unl), .unl_data(wr_data), .locked(locked)
  );

  swl_testmode u_tm (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .tm_wr(hit_tm),
    .tm_data(wr_data[TM_W-1:0]), .tm_q(tm_q), .tm_err(tm_err)
  );

  assign force_hs  = tm_q[B_HS];
  assign force_fs  = tm_q[B_FS];
  assign prbs_en   = tm_q[B_PRBS];
  assign k_state   = tm_q[B_K];
  assign j_state   = tm_q[B_J];
  assign se0_nak   = tm_q[B_SE0];
  assign chirp_dis = force_hs | force_fs;

  a_r6_no_pass_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !wr_pass);

  a_r6_tm_drop_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_en && (wr_addr == TM_ADDR) |=> !tm_err);

  a_r11_chirp: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_dis == (tm_q[B_HS] || tm_q[B_FS]));
endmodule

// File: tb/suspend_wlock_ctrl_tb.sv
module suspend_wlock_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        suspend_evt = 1'b0, resume_evt = 1'b0, proc_pwr = 1'b0;
  logic        wr_pass, locked, force_hs, force_fs, prbs_en, k_state, j_state, se0_nak;
  logic        chirp_dis, tm_err;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [7:0] TMA = 8'h10, UNA = 8'h11;

  always #2.5 clk = ~clk;

  suspend_wlock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .suspend_evt(suspend_evt), .resume_evt(resume_evt),
    .proc_pwr(proc_pwr), .wr_pass(wr_pass), .locked(locked), .force_hs(force_hs),
    .force_fs(force_fs), .prbs_en(prbs_en), .k_state(k_state), .j_state(j_state),
    .se0_nak(se0_nak), .chirp_dis(chirp_dis), .tm_err(tm_err)
  );

  function automatic logic [7:0] tm_now();
    return {force_hs, 2'b00, force_fs, prbs_en, k_state, j_state, se0_nak};
  endfunction

  function automatic bit legal(input logic [7:0] m);
    int s, l;
    s = int'(m[7]) + int'(m[4]);
    l = int'(m[3]) + int'(m[2]) + int'(m[1]) + int'(m[0]);
    return (s <= 1) && (l <= 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_susp(input logic pwr);
    @(negedge clk); suspend_evt = 1'b1; proc_pwr = pwr;
    @(negedge clk); suspend_evt = 1'b0; proc_pwr = 1'b0;
  endtask

  task automatic pulse_res();
    @(negedge clk); resume_evt = 1'b1;
    @(negedge clk); resume_evt = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1'b1;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 locked", 32'(locked), 0);
    chk("R1 tm", 32'(tm_now()), 0);
    chk("R1 err", 32'(tm_err), 0);

    // R6 pass-through while unlocked
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h42; #1;
    chk("R6 pass open", 32'(wr_pass), 1);
    wr_addr = TMA; #1;
    chk("R6 tm addr not passed", 32'(wr_pass), 0);
    @(negedge clk); wr_en = 1'b0;

    // R3 powered suspend does not lock
    pulse_susp(1'b1);
    chk("R3 no lock", 32'(locked), 0);

    // R2 unpowered suspend locks
    pulse_susp(1'b0);
    chk("R2 locked", 32'(locked), 1);
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h42; #1;
    chk("R6 pass blocked", 32'(wr_pass), 0);
    @(negedge clk); wr_en = 1'b0;
    wr(TMA, 16'h0080);
    chk("R6 tm drop", 32'(tm_now()), 0);
    chk("R6 tm drop err", 32'(tm_err), 0);

    // R4 unlock before resume ignored
    wr(UNA, 16'hAA37);
    chk("R4 early unlock", 32'(locked), 1);
    pulse_res();
    chk("R4 resumed still locked", 32'(locked), 1);
    // R5 wrong codes
    wr(UNA, 16'hAA36);
    chk("R5 wrong code", 32'(locked), 1);
    wr(8'h42, 16'hAA37);
    chk("R5 wrong addr", 32'(locked), 1);
    wr(UNA, 16'h37AA);
    chk("R5 swapped code", 32'(locked), 1);
    // R4 correct unlock
    wr(UNA, 16'hAA37);
    chk("R4 unlocked", 32'(locked), 0);
    chk("R6 dropped write left no bit", 32'(tm_now()), 0);

    // R10 bus reset keeps bits
    wr(TMA, 16'h0084);
    chk("R7 hs+K set", 32'(tm_now()), 32'h84);
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    chk("R10 bus reset keeps", 32'(tm_now()), 32'h84);
    wr(TMA, 16'h0000);
    chk("R10 write zero keeps", 32'(tm_now()), 32'h84);
    chk("R11 chirp", 32'(chirp_dis), 1);
    do_reset();
    chk("R10 por clears", 32'(tm_now()), 0);

    // R7 R8 R9 R11 R12 single-write sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] m;
      do_reset();
      m = 8'(v) & 8'h9F;
      wr(TMA, 16'(v));
      if (legal(m)) begin
        chk("R7 field map", 32'(tm_now()), 32'(m));
        chk("R12 no err", 32'(tm_err), 0);
      end else begin
        chk("R8/R9 refused", 32'(tm_now()), 0);
        chk("R12 err pulse", 32'(tm_err), 1);
      end
      chk("R11 chirp", 32'(chirp_dis), 32'(m[7] | m[4]) & 32'(legal(m)));
      @(negedge clk);
      chk("R12 err one cycle", 32'(tm_err), 0);
    end

    // R8 R9 R10 R12 pair sweep from each legal start
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ma;
      ma = 8'(a);
      if ((ma & 8'h60) == 0 && legal(ma) && ma != 0) begin
        for (int b = 0; b < 256; b++) begin
          logic [7:0] mm;
          do_reset();
          wr(TMA, 16'(a));
          mm = ma | (8'(b) & 8'h9F);
          wr(TMA, 16'(b));
          if (legal(mm)) begin
            chk("R10 merge", 32'(tm_now()), 32'(mm));
            chk("R12 no err", 32'(tm_err), 0);
          end else begin
            chk("R9 keep", 32'(tm_now()), 32'(ma));
            chk("R12 err", 32'(tm_err), 1);
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule